// File: doc/BRIEF.md
# Remote Terminal Command Acceptance Logic

This block sits behind the word receiver of a serial-bus remote terminal. It judges each received command word. It decides whether the command is meant for this terminal and whether the terminal answers with a status word. It also decides whether data words may move between the terminal and subsystem memory, and whether the message-error status bit must be raised. For single-word mode codes it gives the offset of the data word within the message block. It also flags mode codes whose reply comes from the terminal's own registers and not from memory.

The terminal's own 5-bit address and its parity bit pass through a strobe-controlled latch. The latch follows its inputs while the strobe is low and freezes them once the strobe is high. An address that fails the odd-parity check silences the terminal and pulls an active-low error output low. A writable table marks individual commands as illegal. An illegal command is still answered with a status word, but it carries the message-error bit and moves no data. Each decision appears on registered outputs one clock after the command is presented.

Top module: `rt_cmd_accept`

## Requirements
- R1: When the latched address bits and parity bit hold an even number of ones, every command yields accept, respond_status, msg_error, data_en and int_src all 0 and mode_offset 0.
- R2: addr_err_n is 0 exactly when the effective address and parity bits (six bits) hold an even number of ones, and 1 otherwise. It follows the effective value without a clock delay.
- R3: While addr_strobe is low, the effective address and parity equal the live inputs, and the hold register loads them at each rising clock edge. While addr_strobe is high, the effective value is the one loaded at the last rising edge where the strobe was low, and later input changes have no effect.
- R4: The command word fields are: terminal address [15:11], direction [10] (1 = transmit), subaddress [9:5], and word count or mode code [4:0]. A command sampled with cmd_valid high at a rising edge produces dec_valid = 1 and its decision after that edge. Without cmd_valid, dec_valid and all decision outputs are 0.
- R5: A command whose address field equals the effective address, is not 31, and has good parity gives accept = 1 and respond_status = 1.
- R6: A command with address field 31 (broadcast) and good parity gives accept = 1 and respond_status = 0.
- R7: A command whose address field is neither the effective address nor 31 gives all decision outputs 0.
- R8: The illegal table holds one bit per {broadcast, direction, subaddress, count}. A write sets row {broadcast, direction, subaddress} (7 bits, broadcast in the MSB) to tbl_wr_bits, where bit n belongs to count n. Reset marks every command legal.
- R9: An accepted command whose table bit is 1 gives msg_error = 1, data_en = 0 and int_src = 0. respond_status is unchanged by the illegal mark.
- R10: Subaddress 0 or 31 marks a mode code. An accepted legal mode code sets data_en = 1 and mode_offset = the code only for codes 16 to 31 other than 18 and 19. For any other code, data_en = 0 and mode_offset = 0.
- R11: An accepted legal transmit mode code 18 or 19 gives int_src = 1. Otherwise int_src is 0.
- R12: An accepted legal command that is not a mode code gives data_en = 1 and mode_offset = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_addr_in | input | 5 | Terminal address inputs |
| rt_par_in | input | 1 | Terminal address parity input |
| addr_strobe | input | 1 | Latch control: low follows, high holds |
| addr_err_n | output | 1 | Low when the effective address parity is even |
| tbl_wr_en | input | 1 | Write one row of the illegal table |
| tbl_wr_row | input | 7 | Row index {broadcast, direction, subaddress} |
| tbl_wr_bits | input | 32 | Illegal bits of the row, bit n = count n |
| cmd_valid | input | 1 | A command word is present this cycle |
| cmd_word | input | 16 | Received command word |
| dec_valid | output | 1 | Decision outputs are valid |
| accept | output | 1 | Command is for this terminal |
| respond_status | output | 1 | Terminal answers with a status word |
| msg_error | output | 1 | Set message-error bit in the status word |
| data_en | output | 1 | Data words move to or from subsystem memory |
| int_src | output | 1 | Reply data comes from internal registers |
| mode_offset | output | 5 | Data word offset for single-word mode codes |

## Verification
Random commands are aimed in roughly equal parts at the own address, the broadcast address and foreign addresses. This separates the address-match path from the broadcast path and from rejection. Random subaddresses and counts are mixed with row writes to the illegal table. This shows that one table bit affects only its own command, and that illegal marks change data movement but not the status reply. Directed cases cover the mode-code boundaries (codes 15, 16, 18, 19 and 31 under subaddresses 0 and 31) and a latched address whose inputs change after the strobe rises. They also cover even parity, which must silence commands that would otherwise be accepted.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;
  localparam int RT_W   = 5;
  localparam int SA_W   = 5;
  localparam int CNT_W  = 5;
  localparam int WORD_W = RT_W + 1 + SA_W + CNT_W;
  localparam int ROW_W  = 2 + SA_W;
  localparam int ROWS   = 2 ** ROW_W;
  localparam int COLS   = 2 ** CNT_W;
  localparam int IDX_W  = ROW_W + CNT_W;
  localparam logic [RT_W-1:0] BCAST_RT = '1;
  localparam logic [SA_W-1:0] MODE_SA_LO = '0;
  localparam logic [SA_W-1:0] MODE_SA_HI = '1;
  localparam logic [CNT_W-1:0] MC_LAST_CMD = 5'd18;
  localparam logic [CNT_W-1:0] MC_SELF_TEST = 5'd19;

  typedef struct packed {
    logic [RT_W-1:0]  rt;
    logic             tx;
    logic [SA_W-1:0]  sa;
    logic [CNT_W-1:0] cnt;
  } cmd_t;

  typedef struct packed {
    logic             accept;
    logic             respond;
    logic             msg_err;
    logic             data_en;
    logic             int_src;
    logic [CNT_W-1:0] offset;
  } decision_t;

  function automatic logic odd_ok(input logic [RT_W-1:0] a, input logic p);
    return ^{a, p};
  endfunction

  function automatic logic is_mode(input logic [SA_W-1:0] sa);
    return (sa == MODE_SA_LO) || (sa == MODE_SA_HI);
  endfunction

  function automatic logic mode_internal(input logic [CNT_W-1:0] code);
    return (code == MC_LAST_CMD) || (code == MC_SELF_TEST);
  endfunction

  function automatic logic mode_mem_word(input logic [CNT_W-1:0] code);
    return code[CNT_W-1] && !mode_internal(code);
  endfunction
endpackage

// File: rtl/rt_addr_latch.sv
module rt_addr_latch
  import rt_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RT_W-1:0] addr_in,
  input  logic            par_in,
  input  logic            strobe,
  output logic [RT_W-1:0] addr_eff,
  output logic            par_eff
);
  logic [RT_W-1:0] held_addr;
  logic            held_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_par  <= 1'b0;
    end else if (!strobe) begin
      held_addr <= addr_in;
      held_par  <= par_in;
    end
  end

  assign addr_eff = strobe ? held_addr : addr_in;
  assign par_eff  = strobe ? held_par  : par_in;
endmodule

// File: rtl/rt_illegal_table.sv
module rt_illegal_table
  import rt_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COLS-1:0]  wr_bits,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [COLS-1:0] rows [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rows[r] <= '0;
      else if (wr_en && (wr_row == ROW_W'(r)))
        rows[r] <= wr_bits;
    end
  end

  logic [ROW_W-1:0] rd_row;
  logic [CNT_W-1:0] rd_col;
  assign rd_row = rd_idx[IDX_W-1:CNT_W];
  assign rd_col = rd_idx[CNT_W-1:0];
  assign rd_bit = rows[rd_row][rd_col];
endmodule

// File: rtl/rt_cmd_classify.sv
module rt_cmd_classify
  import rt_cmd_pkg::*;
(
  input  cmd_t            cmd,
  input  logic [RT_W-1:0] addr_eff,
  input  logic            par_eff,
  input  logic            ill_bit,
  output logic            par_ok,
  output logic            own_hit,
  output logic            bcast_hit,
  output decision_t       dec
);
  logic mode_w, legal_acc;

  always_comb begin
    par_ok    = odd_ok(addr_eff, par_eff);
    bcast_hit = (cmd.rt == BCAST_RT);
    own_hit   = !bcast_hit && (cmd.rt == addr_eff);
    mode_w    = is_mode(cmd.sa);

    dec         = '0;
    dec.accept  = par_ok && (own_hit || bcast_hit);
    dec.respond = par_ok && own_hit;
    dec.msg_err = dec.accept && ill_bit;
    legal_acc   = dec.accept && !ill_bit;
    dec.data_en = legal_acc && (!mode_w || mode_mem_word(cmd.cnt));
    dec.int_src = legal_acc && mode_w && cmd.tx && mode_internal(cmd.cnt);
    dec.offset  = (dec.data_en && mode_w) ? cmd.cnt : '0;
  end
endmodule

// File: rtl/rt_cmd_accept.sv
module rt_cmd_accept
  import rt_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RT_W-1:0]   rt_addr_in,
  input  logic              rt_par_in,
  input  logic              addr_strobe,
  output logic              addr_err_n,
  input  logic              tbl_wr_en,
  input  logic [ROW_W-1:0]  tbl_wr_row,
  input  logic [COLS-1:0]   tbl_wr_bits,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              dec_valid,
  output logic              accept,
  output logic              respond_status,
  output logic              msg_error,
  output logic              data_en,
  output logic              int_src,
  output logic [CNT_W-1:0]  mode_offset
);
  cmd_t             cmd_w;
  logic [RT_W-1:0]  eff_addr_w;
  logic             eff_par_w;
  logic             par_ok_w, own_hit_w, bcast_hit_w, ill_bit_w;
  logic [IDX_W-1:0] tbl_idx_w;
  decision_t        dec_w, dec_q;

  assign cmd_w = cmd_t'(cmd_word);

  rt_addr_latch i_latch (
    .clk(clk), .rst_n(rst_n), .addr_in(rt_addr_in), .par_in(rt_par_in),
    .strobe(addr_strobe), .addr_eff(eff_addr_w), .par_eff(eff_par_w)
  );

  assign tbl_idx_w = {(cmd_w.rt == BCAST_RT), cmd_w.tx, cmd_w.sa, cmd_w.cnt};

  rt_illegal_table i_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_row(tbl_wr_row),
    .wr_bits(tbl_wr_bits), .rd_idx(tbl_idx_w), .rd_bit(ill_bit_w)
  );

  rt_cmd_classify i_cls (
    .cmd(cmd_w), .addr_eff(eff_addr_w), .par_eff(eff_par_w), .ill_bit(ill_bit_w),
    .par_ok(par_ok_w), .own_hit(own_hit_w), .bcast_hit(bcast_hit_w), .dec(dec_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_q     <= '0;
    end else begin
      dec_valid <= cmd_valid;
      dec_q     <= cmd_valid ? dec_w : '0;
    end
  end

  assign addr_err_n     = par_ok_w;
  assign accept         = dec_q.accept;
  assign respond_status = dec_q.respond;
  assign msg_error      = dec_q.msg_err;
  assign data_en        = dec_q.data_en;
  assign int_src        = dec_q.int_src;
  assign mode_offset    = dec_q.offset;
endmodule

// File: rtl/rt_cmd_accept_chk.sv
module rt_cmd_accept_chk
  import rt_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             cmd_valid,
  input logic             par_ok,
  input logic             own_hit,
  input logic             bcast_hit,
  input logic [RT_W:0]    eff_val,
  input logic             dec_valid,
  input logic             accept,
  input logic             respond_status,
  input logic             msg_error,
  input logic             data_en,
  input logic             int_src,
  input logic [CNT_W-1:0] mode_offset
);
  a_r1_bad_parity_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !par_ok |=> !accept && !respond_status && !data_en);

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && $past(strobe) |-> $stable(eff_val));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !accept && !respond_status && !msg_error && !data_en && !int_src);

  a_r5_own_responds: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && par_ok && own_hit |=> accept && respond_status);

  a_r6_bcast_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && bcast_hit |=> !respond_status);

  a_r9_illegal_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    msg_error |-> accept && !data_en && !int_src);

  a_r10_offset_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    mode_offset != '0 |-> data_en);

  a_r11_int_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    int_src |-> !data_en && accept);
endmodule

bind rt_cmd_accept rt_cmd_accept_chk i_chk (
  .clk(clk), .rst_n(rst_n), .strobe(addr_strobe), .cmd_valid(cmd_valid),
  .par_ok(par_ok_w), .own_hit(own_hit_w), .bcast_hit(bcast_hit_w),
  .eff_val({eff_addr_w, eff_par_w}), .dec_valid(dec_valid), .accept(accept),
  .respond_status(respond_status), .msg_error(msg_error), .data_en(data_en),
  .int_src(int_src), .mode_offset(mode_offset)
);

// File: tb/test_rt_cmd_accept.sv
module test_rt_cmd_accept;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] rt_addr_in = '0;
  logic rt_par_in = 1'b0, addr_strobe = 1'b0, addr_err_n;
  logic tbl_wr_en = 1'b0;
  logic [6:0] tbl_wr_row = '0;
  logic [31:0] tbl_wr_bits = '0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic dec_valid, accept, respond_status, msg_error, data_en, int_src;
  logic [4:0] mode_offset;

  int checks = 0, errors = 0;
  logic [4095:0] m_tbl = '0;
  logic [5:0] m_held = '0;

  always #2.5 clk = ~clk;

  rt_cmd_accept i_rt_cmd_accept (.*);

  // R3: model hold register, loaded at rising edges while strobe is low
  always @(posedge clk) if (rst_n && !addr_strobe) m_held <= {rt_addr_in, rt_par_in};

  function automatic logic [5:0] eff();
    return addr_strobe ? m_held : {rt_addr_in, rt_par_in};
  endfunction

  // expected {dec_valid, accept, respond, msg, data, int, offset[4:0]}
  function automatic logic [10:0] expect_dec(input logic [15:0] w, input logic [5:0] e);
    logic pok, bc, own, acc, ill, mode, mem, dat, isrc;
    logic [4:0] code, sa;
    code = w[4:0]; sa = w[9:5];
    pok  = ($countones(e) % 2) == 1;
    bc   = w[15:11] == 5'd31;
    own  = !bc && (w[15:11] == e[5:1]);
    acc  = pok && (bc || own);
    ill  = m_tbl[{bc, w[10:0]}];
    mode = (sa == 5'd0) || (sa == 5'd31);
    mem  = (code >= 5'd16) && (code != 5'd18) && (code != 5'd19);
    dat  = acc && !ill && (!mode || mem);
    isrc = acc && !ill && mode && w[10] && (code == 5'd18 || code == 5'd19);
    return {1'b1, acc, acc && !bc, acc && ill, dat, isrc, (dat && mode) ? code : 5'd0};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [4:0] a, input logic p, input logic s);
    @(negedge clk);
    rt_addr_in = a; rt_par_in = p; addr_strobe = s;
    #0.5;
    checks++;
    if (addr_err_n !== (($countones(eff()) % 2) == 1)) begin
      errors++;
      $display("FAIL R2 actual %b expected %b", addr_err_n, ($countones(eff()) % 2) == 1);
    end
  endtask

  task automatic wr_row(input logic [6:0] r, input logic [31:0] b);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_row = r; tbl_wr_bits = b;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    m_tbl[{r, 5'd0} +: 32] = b;
  endtask

  task automatic send(input string req, input logic [15:0] w);
    logic [10:0] ex;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    ex = expect_dec(w, eff());
    @(negedge clk);
    cmd_valid = 1'b0;
    check(req, {dec_valid, accept, respond_status, msg_error, data_en, int_src, mode_offset}, ex);
  endtask

  function automatic logic [15:0] mk(input logic [4:0] rt, input logic tx,
                                      input logic [4:0] sa, input logic [4:0] c);
    return {rt, tx, sa, c};
  endfunction

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    @(negedge clk);
    check("R4 reset", {dec_valid, accept, respond_status, msg_error, data_en, int_src, mode_offset}, 11'd0);

    // address 5 (00101) + parity 1 => three ones, odd
    set_addr(5'd5, 1'b1, 1'b0);
    send("R5 own", mk(5'd5, 1'b0, 5'd3, 5'd4));
    send("R12 own tx data", mk(5'd5, 1'b1, 5'd30, 5'd0));
    send("R7 foreign", mk(5'd6, 1'b0, 5'd3, 5'd4));
    send("R6 broadcast", mk(5'd31, 1'b0, 5'd3, 5'd4));
    // R10 mode code boundaries
    send("R10 code15", mk(5'd5, 1'b1, 5'd0, 5'd15));
    send("R10 code16", mk(5'd5, 1'b1, 5'd0, 5'd16));
    send("R10 code17 sa31", mk(5'd5, 1'b0, 5'd31, 5'd17));
    send("R10 code31", mk(5'd5, 1'b0, 5'd31, 5'd31));
    send("R11 code18 tx", mk(5'd5, 1'b1, 5'd0, 5'd18));
    send("R11 code19 tx", mk(5'd5, 1'b1, 5'd31, 5'd19));
    send("R11 code19 rx", mk(5'd5, 1'b0, 5'd31, 5'd19));
    // R8 R9 illegal marks
    wr_row(7'b0_0_00011, 32'h0000_0010);
    send("R9 illegal own", mk(5'd5, 1'b0, 5'd3, 5'd4));
    send("R8 neighbour legal", mk(5'd5, 1'b0, 5'd3, 5'd5));
    wr_row(7'b1_0_00011, 32'h0000_0010);
    send("R9 illegal bcast", mk(5'd31, 1'b0, 5'd3, 5'd4));
    wr_row(7'b0_1_00000, 32'h0008_0000);
    send("R9 illegal code19", mk(5'd5, 1'b1, 5'd0, 5'd19));
    // R1 even parity silences everything
    set_addr(5'd5, 1'b0, 1'b0);
    send("R1 bad parity own", mk(5'd5, 1'b0, 5'd3, 5'd7));
    send("R1 bad parity bcast", mk(5'd31, 1'b0, 5'd3, 5'd7));
    // R3 latch: freeze address 9 (01001) par 1
    set_addr(5'd9, 1'b1, 1'b0);
    set_addr(5'd9, 1'b1, 1'b1);
    set_addr(5'd12, 1'b0, 1'b1);
    send("R3 held addr", mk(5'd9, 1'b0, 5'd2, 5'd1));
    send("R3 live ignored", mk(5'd12, 1'b0, 5'd2, 5'd1));
    set_addr(5'd12, 1'b1, 1'b0);
    send("R3 follows again", mk(5'd12, 1'b0, 5'd2, 5'd1));

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] rt;
      int sel;
      if (i % 25 == 0) wr_row(7'($urandom), $urandom);
      if (i % 40 == 0) set_addr(5'($urandom), 1'($urandom), 1'(($urandom % 3) == 0));
      sel = $urandom % 3;
      rt = (sel == 0) ? eff()[5:1] : (sel == 1) ? 5'd31 : 5'($urandom);
      send("R5 R6 R7 R8 R9 R10 R11 R12 random",
           mk(rt, 1'($urandom), (($urandom % 4) == 0) ? 5'd0 : 5'($urandom), 5'($urandom)));
    end
    @(negedge clk);
    check("R4 idle", {dec_valid, accept, respond_status, msg_error, data_en, int_src, mode_offset}, 11'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule